// File: doc/BRIEF.md
# Two-Phase Peripheral Bus Master

This block turns single requests from a host into transfers on a simple, non-pipelined peripheral bus with one slave. Each transfer takes two bus cycles: a setup cycle, in which the slave is selected and the address, direction and write data are presented, and an access cycle, in which the enable strobe is raised and the slave completes the transfer. There are no wait states, so the access cycle always lasts exactly one clock.

The host offers a request with a valid strobe and the block takes it whenever it is not in the setup cycle. A request taken during an access cycle chains straight into a new setup cycle with no idle cycle between. Writes report completion during their access cycle. Reads capture the slave's data at the clock edge that ends the access cycle and return it, with the completion pulse, in the following cycle.

Top module: `busm_master`

## Requirements
- R1: While rst_n (active low, sampled at the clock edge) is low, and in the first cycle after it, bus_sel=0, bus_en=0, host_done=0 and host_ready=1.
- R2: The bus phase is encoded on (bus_sel, bus_en): idle is (0,0), setup is (1,0), access is (1,1); the pair (0,1) is never driven.
- R3: host_ready is high in the idle and access phases and low in setup; a request with host_valid high while host_ready is high is accepted, and the next cycle is a setup phase carrying that request's address, write flag and write data.
- R4: A setup phase is always followed by an access phase in the next cycle.
- R5: An access phase is followed by a setup phase if a request was accepted in that cycle and by idle otherwise; idle persists while no request is accepted.
- R6: bus_sel, bus_addr, bus_write and bus_wdata hold the same values from the setup phase into the access phase.
- R7: For a write, host_done is high for exactly the access cycle of that write.
- R8: For a read, bus_rdata is captured at the clock edge ending the access phase and appears on host_rdata with host_done high for the one following cycle.
- R9: host_valid asserted during a setup phase is ignored: it changes neither the bus values of the transfer in progress nor the phase that follows its access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_valid | input | 1 | Host request strobe |
| host_write | input | 1 | Request direction, 1 = write |
| host_addr | input | AW | Request address |
| host_wdata | input | DW | Request write data |
| host_ready | output | 1 | Block can accept a request this cycle |
| host_done | output | 1 | Completion pulse |
| host_rdata | output | DW | Read data returned with a read completion |
| bus_sel | output | 1 | Slave select |
| bus_en | output | 1 | Access-phase enable strobe |
| bus_addr | output | AW | Bus address |
| bus_write | output | 1 | Bus direction, 1 = write |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Slave read data |

## Verification
The bench drives chains of mixed reads and writes in which a new request arrives during the access cycle; a design that dropped it or inserted an idle cycle would show sel low, or a late setup, in the cycle after access. It raises host_valid with a different address during setup, where a design that accepted it would corrupt the bus address in the access phase or start an unwanted transfer. It checks the read return one cycle after access with the slave data changed afterwards, which catches capture on the wrong edge, and it resets in the middle of an access phase to see the bus drop back to idle.

// File: rtl/busm_pkg.sv
// Shared types for the two-phase bus master.
// Assumes: nothing beyond IEEE 1800-2017.
package busm_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } phase_e;
endpackage

// File: rtl/busm_phase_fsm.sv
// Bus phase sequencer: idle -> setup -> access, with access able to
// chain directly into setup when a request is accepted there.
// Assumes: accept is only asserted in idle or access.
module busm_phase_fsm
    import busm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   accept,
    output phase_e phase
);
    phase_e phase_q, phase_d;

    // Next-phase selection.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE:   phase_d = accept ? PH_SETUP : PH_IDLE;
            PH_SETUP:  phase_d = PH_ACCESS;
            PH_ACCESS: phase_d = accept ? PH_SETUP : PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    // Phase register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    assign phase = phase_q;
endmodule

// File: rtl/busm_req_capture.sv
// Request holding register: loads address, direction and write data on
// acceptance and keeps them until the next accepted request.
// Assumes: load is never high in the setup phase.
module busm_req_capture #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          in_write,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_wdata,
    output logic          q_write,
    output logic [AW-1:0] q_addr,
    output logic [DW-1:0] q_wdata
);
    // Capture the request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_write <= 1'b0;
            q_addr  <= '0;
            q_wdata <= '0;
        end else if (load) begin
            q_write <= in_write;
            q_addr  <= in_addr;
            q_wdata <= in_wdata;
        end
    end
endmodule

// File: rtl/busm_read_return.sv
// Completion logic: write completion during access, read data captured
// at the end of access and returned with a pulse one cycle later.
// Assumes: no wait states, so access always lasts one cycle.
module busm_read_return #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_access,
    input  logic          is_write,
    input  logic [DW-1:0] slave_rdata,
    output logic          done,
    output logic [DW-1:0] rdata
);
    logic          rd_done_q;
    logic [DW-1:0] rdata_q;
    logic          rd_access;

    assign rd_access = in_access & ~is_write;

    // Read completion flag and data capture at the end of access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_done_q <= 1'b0;
            rdata_q   <= '0;
        end else begin
            rd_done_q <= rd_access;
            if (rd_access) rdata_q <= slave_rdata;
        end
    end

    // Merge write and read completion onto one pulse.
    always_comb begin
        done = (in_access & is_write) | rd_done_q;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/busm_master.sv
// Two-phase bus master for a single slave. Host requests are accepted
// in idle or access, registered, and driven through setup and access.
// Assumes: synchronous active-low reset; slave never inserts wait states.
module busm_master
    import busm_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_valid,
    input  logic          host_write,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic          host_ready,
    output logic          host_done,
    output logic [DW-1:0] host_rdata,
    output logic          bus_sel,
    output logic          bus_en,
    output logic [AW-1:0] bus_addr,
    output logic          bus_write,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata
);
    phase_e phase;
    logic   accept;
    logic   in_access;

    // Acceptance: allowed everywhere but setup.
    always_comb begin
        host_ready = (phase != PH_SETUP);
        accept     = host_valid & host_ready;
        in_access  = (phase == PH_ACCESS);
    end

    busm_phase_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .phase  (phase)
    );

    busm_req_capture #(.AW(AW), .DW(DW)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .in_write (host_write),
        .in_addr  (host_addr),
        .in_wdata (host_wdata),
        .q_write  (bus_write),
        .q_addr   (bus_addr),
        .q_wdata  (bus_wdata)
    );

    busm_read_return #(.DW(DW)) u_ret (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_access   (in_access),
        .is_write    (bus_write),
        .slave_rdata (bus_rdata),
        .done        (host_done),
        .rdata       (host_rdata)
    );

    // Phase to bus strobe decode.
    always_comb begin
        bus_sel = (phase != PH_IDLE);
        bus_en  = in_access;
    end
endmodule

// File: rtl/busm_checker.sv
// Protocol checker for busm_master, observing its ports only.
// Assumes: attached by the bind below.
module busm_checker #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_en,
    input logic          bus_write,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          host_ready,
    input logic          host_done
);
    // R2
    illegal_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_sel && bus_en));

    // R5
    idle_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel && !bus_en) |=> !bus_en);

    // R4
    setup_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_en) |=> (bus_sel && bus_en));

    // R5
    access_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_en) |=> !bus_en);

    // R6
    hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_en) |=> ($stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)));

    // R3
    setup_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_en) |-> !host_ready);

    // R7
    write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_en && bus_write) |-> host_done);

    // R8
    read_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_en && !bus_write) |=> host_done);
endmodule

bind busm_master busm_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_en     (bus_en),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .host_ready (host_ready),
    .host_done  (host_done)
);

// File: tb/busm_master_tb.sv
`timescale 1ns/1ps
module busm_master_tb;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int NV = 7;
    localparam int VW = 2 + AW + 2*DW;

    // Vector: {chain_next, write, addr, wdata, slave_rdata}
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b0, 1'b1, 8'h10, 16'hA5A5, 16'h0000},
        {1'b0, 1'b0, 8'h24, 16'h0000, 16'h1234},
        {1'b1, 1'b1, 8'h31, 16'h00FF, 16'h0000},
        {1'b1, 1'b0, 8'h42, 16'h0000, 16'hBEEF},
        {1'b1, 1'b0, 8'h53, 16'h0000, 16'hC0DE},
        {1'b0, 1'b1, 8'h64, 16'h7E57, 16'h0000},
        {1'b0, 1'b0, 8'hFF, 16'h0000, 16'hFFFF}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_valid = 1'b0;
    logic          host_write = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_ready, host_done;
    logic [DW-1:0] host_rdata;
    logic          bus_sel, bus_en, bus_write;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    busm_master #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_valid(host_valid), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_done(host_done), .host_rdata(host_rdata),
        .bus_sel(bus_sel), .bus_en(bus_en), .bus_addr(bus_addr),
        .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive_req(input logic [VW-1:0] v);
        host_valid = 1'b1;
        host_write = v[2*DW+AW];
        host_addr  = v[2*DW +: AW];
        host_wdata = v[DW +: DW];
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit chained;
        // Reset state, R1
        repeat (3) @(negedge clk);
        chk("R1", {bus_sel, bus_en, host_done, host_ready}, 4'b0001);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {bus_sel, bus_en, host_done, host_ready}, 4'b0001);
        chk("R5", {bus_sel, bus_en}, 2'b00);

        // Vector table walk: R2 R3 R4 R5 R6 R7 R8
        chained = 0;
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            if (!chained) begin
                chk("R3", host_ready, 1'b1);
                drive_req(v);
                @(negedge clk);
            end
            // setup phase
            host_valid = 1'b0;
            chk("R2", {bus_sel, bus_en}, 2'b10);
            chk("R3", {bus_write, bus_addr, bus_wdata}, {v[2*DW+AW], v[2*DW +: AW], v[DW +: DW]});
            chk("R3", host_ready, 1'b0);
            bus_rdata = v[DW-1:0];
            @(negedge clk);
            // access phase
            chk("R4", {bus_sel, bus_en}, 2'b11);
            chk("R6", {bus_write, bus_addr, bus_wdata}, {v[2*DW+AW], v[2*DW +: AW], v[DW +: DW]});
            chk("R7", host_done, v[2*DW+AW]);
            chk("R3", host_ready, 1'b1);
            chained = v[VW-1] && (i + 1 < NV);
            if (chained) drive_req(VEC[i+1]);
            else host_valid = 1'b0;
            @(negedge clk);
            bus_rdata = ~v[DW-1:0];
            // cycle after access
            if (v[2*DW+AW]) begin
                chk("R7", host_done, 1'b0);
            end else begin
                chk("R8", host_done, 1'b1);
                chk("R8", host_rdata, v[DW-1:0]);
            end
            chk("R5", {bus_sel, bus_en}, chained ? 2'b10 : 2'b00);
            if (!chained) begin
                @(negedge clk);
                chk("R8", host_done, 1'b0);
            end
        end

        // Idle persists without requests, R5
        repeat (3) @(negedge clk);
        chk("R5", {bus_sel, bus_en, host_done}, 3'b000);

        // Valid during setup is ignored, R9
        drive_req({1'b0, 1'b1, 8'h77, 16'h1111, 16'h0000});
        @(negedge clk);
        drive_req({1'b0, 1'b0, 8'h55, 16'h2222, 16'h0000});
        @(negedge clk);
        host_valid = 1'b0;
        chk("R9", {bus_sel, bus_en}, 2'b11);
        chk("R9", {bus_write, bus_addr, bus_wdata}, {1'b1, 8'h77, 16'h1111});
        @(negedge clk);
        chk("R9", {bus_sel, bus_en}, 2'b00);
        chk("R9", {bus_write, bus_addr, bus_wdata}, {1'b1, 8'h77, 16'h1111});

        // Reset in the middle of an access phase, R1
        drive_req({1'b0, 1'b0, 8'h99, 16'h0000, 16'h0000});
        bus_rdata = 16'h4321;
        @(negedge clk);
        host_valid = 1'b0;
        @(negedge clk);
        chk("R2", {bus_sel, bus_en}, 2'b11);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", {bus_sel, bus_en, host_done, host_ready}, 4'b0001);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {bus_sel, bus_en, host_done}, 3'b000);

        finish_run();
    end
endmodule